// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block watches CPU writes to the upper half of the address map and keeps a small file of bank registers. From those registers it produces, purely combinationally, the bank numbers used by the surrounding memory system. It covers four 8 KB program windows, eight 1 KB pattern windows and four 1 KB name-table windows. It also produces a per-slot write enable for an 8 KB work RAM that is split into four 2 KB slots.

A 1 KB register holds one byte. When that byte is 0xE0 or higher, the window is served from on-chip name-table RAM and is writable. Otherwise the byte is a ROM bank number. Two bits of the second program register can force each half of the pattern space back to ROM. The work RAM stays locked unless the protection byte carries the right key nibble. The memories themselves live outside the block. A write changes the register at the clock edge, and the new mapping is visible from the next cycle onward.

Top module: `bank_mapper_top`

## Requirements
- R1: After reset, the 8 KB windows 0..3 show banks 0x3C, 0x3D, 0x3E and 0x3F. Pattern windows 0..7 show ROM banks 0..7. Name-table windows 8..11 show RAM pages 0, 1, 0, 1. No work RAM slot is writable.
- R2: A write with page input `wr_page` = {1, i}, where i is 0..11 (CPU addresses 0x8000 + 0x800*i), loads 1 KB register i with `wr_data`. Window i then reflects the new value.
- R3: Pages 0x1C, 0x1D and 0x1E (CPU 0xE000, 0xE800, 0xF000) load the bank of 8 KB windows 0, 1 and 2 from data bits 5:0. Window 3 always shows bank 0x3F.
- R4: A 1 KB register value below 0xE0 gives `win_ram`=0 and a bank equal to the value. A value of 0xE0 or above gives `win_ram`=1 and RAM page (value AND 1), or (value AND 3) while `four_screen`=1.
- R5: Bit 6 of the byte written to page 0x1D forces pattern windows 0..3 to ROM, and bit 7 forces pattern windows 4..7 to ROM. A forced window shows the raw register value with `win_ram`=0.
- R6: The force bits never affect name-table windows 8..11.
- R7: Page 0x1F (CPU 0xF800) stores the protection byte. Slot s (bit s of `wram_slot_wr`, CPU address bits 12:11 inside 0x6000..0x7FFF) is writable only when bits 7:4 of the byte equal 0x4 and bit s of the byte is 0.
- R8: Writes whose page bit 4 is 0 (CPU addresses below 0x8000) change no register and no output.
- R9: Outputs keep their old value until the clock edge that takes the write. They show the new mapping in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_page | input | 5 | CPU address bits 15:11 of the write |
| wr_data | input | 8 | CPU write data |
| four_screen | input | 1 | Selects four RAM pages instead of two |
| win_bank | output | 96 | Bank or RAM page per 1 KB window, 8 bits each, window 0 in the low byte |
| win_ram | output | 12 | Per 1 KB window: 1 = internal RAM (writable), 0 = ROM |
| prg_bank | output | 24 | 6-bit bank per 8 KB window, window 0 lowest |
| wram_slot_wr | output | 4 | Per 2 KB work RAM slot write enable |

## Verification
The mapping is driven with values on both sides of 0xE0, in both page-count modes, and with each force bit set and clear. This separates the RAM/ROM threshold, the page mask and the split of the force bits between the two halves. It also shows that name-table windows ignore forcing. Protection bytes with the right key and mixed lock bits, with all slots open, and with a wrong key show that the key and the per-slot bits are decoded apart. Writes below 0x8000 and a probe taken before the capturing edge pin down the ignore rule and the one-cycle latency.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int KB_REGS    = 12;
  localparam int PAT_WINS   = 8;
  localparam int PAT_HALF   = PAT_WINS / 2;
  localparam int PRG_REGS   = 3;
  localparam int PRG_WINS   = PRG_REGS + 1;
  localparam int PRG_W      = 6;
  localparam int PRG_BASE   = 12;
  localparam int FORCE_REG  = 1;
  localparam int WP_IDX     = 15;
  localparam int WR_SLOTS   = 4;
  localparam logic [7:0] RAM_THRESH = 8'hE0;
  localparam logic [3:0] WP_KEY     = 4'h4;

  function automatic logic [7:0] kb_reset(input int idx);
    if (idx < PAT_WINS) return 8'(idx);
    return RAM_THRESH | 8'(idx & 1);
  endfunction

  function automatic logic [PRG_W-1:0] prg_reset(input int idx);
    return PRG_W'(8'hFC + idx);
  endfunction

  function automatic logic [7:0] ram_page(input logic [7:0] v, input logic fs);
    return fs ? {6'b0, v[1:0]} : {7'b0, v[0]};
  endfunction
endpackage

// File: rtl/map_regs.sv
module map_regs
  import bank_mapper_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [4:0]                wr_page,
  input  logic [7:0]                wr_data,
  output logic [KB_REGS*8-1:0]      kb_flat,
  output logic [PRG_REGS*PRG_W-1:0] prg_flat,
  output logic                      force_lo,
  output logic                      force_hi,
  output logic [7:0]                wp_q
);
  logic       sel_hit;
  logic [3:0] idx;
  logic [7:0] kb_q [KB_REGS];
  logic [PRG_W-1:0] prg_q [PRG_REGS];
  logic [1:0] frc_q;

  assign sel_hit = wr_en & wr_page[4];
  assign idx     = wr_page[3:0];

  for (genvar g = 0; g < KB_REGS; g++) begin : g_kb
    always_ff @(posedge clk) begin
      if (!rst_n)                            kb_q[g] <= kb_reset(g);
      else if (sel_hit && idx == 4'(g))      kb_q[g] <= wr_data;
    end
    assign kb_flat[g*8 +: 8] = kb_q[g];
    a_r2_kb_load: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_hit && idx == 4'(g)) |=> (kb_q[g] == $past(wr_data)));
  end

  for (genvar g = 0; g < PRG_REGS; g++) begin : g_prg
    always_ff @(posedge clk) begin
      if (!rst_n)                                 prg_q[g] <= prg_reset(g);
      else if (sel_hit && idx == 4'(PRG_BASE + g)) prg_q[g] <= wr_data[PRG_W-1:0];
    end
    assign prg_flat[g*PRG_W +: PRG_W] = prg_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frc_q <= 2'b11;
      wp_q  <= 8'hFF;
    end else begin
      if (sel_hit && idx == 4'(PRG_BASE + FORCE_REG)) frc_q <= wr_data[7:6];
      if (sel_hit && idx == 4'(WP_IDX))               wp_q  <= wr_data;
    end
  end

  assign force_lo = frc_q[0];
  assign force_hi = frc_q[1];

  // R8: low-page writes leave every register untouched
  a_r8_low_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_page[4]) |=> ($stable(kb_flat) && $stable(prg_flat) &&
                                $stable(frc_q) && $stable(wp_q)));
endmodule

// File: rtl/win_map.sv
module win_map
  import bank_mapper_pkg::*;
(
  input  logic [7:0] value,
  input  logic       force_rom,
  input  logic       four_screen,
  output logic [7:0] bank,
  output logic       is_ram
);
  logic ram_sel;
  assign ram_sel = (value >= RAM_THRESH) && !force_rom;

  always_comb begin
    is_ram = ram_sel;
    bank   = ram_sel ? ram_page(value, four_screen) : value;
  end
endmodule

// File: rtl/wram_guard.sv
module wram_guard
  import bank_mapper_pkg::*;
(
  input  logic [7:0]          wp,
  output logic [WR_SLOTS-1:0] slot_wr
);
  logic key_ok;
  assign key_ok = (wp[7:4] == WP_KEY);

  for (genvar s = 0; s < WR_SLOTS; s++) begin : g_slot
    assign slot_wr[s] = key_ok && !wp[s];
  end
endmodule

// File: rtl/bank_mapper_top.sv
module bank_mapper_top
  import bank_mapper_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [4:0]                wr_page,
  input  logic [7:0]                wr_data,
  input  logic                      four_screen,
  output logic [KB_REGS*8-1:0]      win_bank,
  output logic [KB_REGS-1:0]        win_ram,
  output logic [PRG_WINS*PRG_W-1:0] prg_bank,
  output logic [WR_SLOTS-1:0]       wram_slot_wr
);
  logic [KB_REGS*8-1:0]      kb_flat;
  logic [PRG_REGS*PRG_W-1:0] prg_flat;
  logic                      force_lo;
  logic                      force_hi;
  logic [7:0]                wp_q;

  map_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_page  (wr_page),
    .wr_data  (wr_data),
    .kb_flat  (kb_flat),
    .prg_flat (prg_flat),
    .force_lo (force_lo),
    .force_hi (force_hi),
    .wp_q     (wp_q)
  );

  for (genvar g = 0; g < KB_REGS; g++) begin : g_win
    logic frc;
    if (g < PAT_HALF) begin : g_lo
      assign frc = force_lo;
    end else if (g < PAT_WINS) begin : g_hi
      assign frc = force_hi;
    end else begin : g_nt
      assign frc = 1'b0;
      // R6: name-table windows follow their value regardless of force bits
      a_r6_nt_unforced: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_flat[g*8 +: 8] >= RAM_THRESH) |-> win_ram[g]);
    end
    win_map u_win (
      .value       (kb_flat[g*8 +: 8]),
      .force_rom   (frc),
      .four_screen (four_screen),
      .bank        (win_bank[g*8 +: 8]),
      .is_ram      (win_ram[g])
    );
  end

  assign prg_bank[PRG_REGS*PRG_W-1:0]                 = prg_flat;
  assign prg_bank[PRG_WINS*PRG_W-1 -: PRG_W]          = '1;

  wram_guard u_guard (
    .wp      (wp_q),
    .slot_wr (wram_slot_wr)
  );

  // R5: force bits keep the pattern halves on ROM
  a_r5_force_lo: assert property (@(posedge clk) disable iff (!rst_n)
    force_lo |-> (win_ram[PAT_HALF-1:0] == '0));
  a_r5_force_hi: assert property (@(posedge clk) disable iff (!rst_n)
    force_hi |-> (win_ram[PAT_WINS-1:PAT_HALF] == '0));
  // R7: without the key nibble no slot opens
  a_r7_key_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_q[7:4] != WP_KEY) |-> (wram_slot_wr == '0));
  // R9: a program bank write shows on the next cycle
  a_r9_prg0_next: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_page == 5'h1C) |=> (prg_bank[PRG_W-1:0] == $past(wr_data[PRG_W-1:0])));
endmodule

// File: tb/sim_bank_mapper_top.sv
`timescale 1ns/1ps
module sim_bank_mapper_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_page = '0;
  logic [7:0]  wr_data = '0;
  logic        four_screen = 1'b0;
  logic [95:0] win_bank;
  logic [11:0] win_ram;
  logic [23:0] prg_bank;
  logic [3:0]  wram_slot_wr;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int    q_sel[$];
  int    q_exp[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  bank_mapper_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_page(wr_page), .wr_data(wr_data),
    .four_screen(four_screen), .win_bank(win_bank), .win_ram(win_ram),
    .prg_bank(prg_bank), .wram_slot_wr(wram_slot_wr)
  );

  // selector: 0..11 bank, 12..23 ram flag, 24..27 prg bank, 28 slot vector
  function automatic int obs(int s);
    if (s < 12) return int'(win_bank[s*8 +: 8]);
    if (s < 24) return int'(win_ram[s-12]);
    if (s < 28) return int'(prg_bank[(s-24)*6 +: 6]);
    return int'(wram_slot_wr);
  endfunction

  function automatic int m_bank(int v, bit frc, bit fs);
    if (v >= 224 && !frc) return fs ? (v & 3) : (v & 1);
    return v;
  endfunction

  function automatic int m_ram(int v, bit frc);
    return (v >= 224 && !frc) ? 1 : 0;
  endfunction

  function automatic int m_slots(int wp);
    int r = 0;
    if ((wp >> 4) == 4)
      for (int s = 0; s < 4; s++) if (((wp >> s) & 1) == 0) r |= (1 << s);
    return r;
  endfunction

  task automatic check(int s, int e, string t);
    tests++;
    if (obs(s) != e) begin
      fails++;
      $display("FAIL %s sel=%0d actual=%0d expected=%0d", t, s, obs(s), e);
    end
  endtask

  task automatic expect_win(int w, int v, bit frc, string t);
    q_sel.push_back(w);      q_exp.push_back(m_bank(v, frc, four_screen)); q_tag.push_back(t);
    q_sel.push_back(w + 12); q_exp.push_back(m_ram(v, frc));               q_tag.push_back(t);
  endtask

  task automatic expect_val(int s, int e, string t);
    q_sel.push_back(s); q_exp.push_back(e); q_tag.push_back(t);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_page = a[15:11]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  // monitor: pops and compares pending expectations after each edge
  initial begin
    forever begin
      @(posedge clk); #1;
      while (q_sel.size() > 0) check(q_sel.pop_front(), q_exp.pop_front(), q_tag.pop_front());
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 8; i++) expect_win(i, i, 1'b1, "R1 pattern reset");
    for (int i = 8; i < 12; i++) expect_win(i, 224 | (i & 1), 1'b0, "R1 nametable reset");
    for (int i = 0; i < 4; i++) expect_val(24 + i, 60 + i, "R1 prg reset");
    expect_val(28, 0, "R1 wram locked");
    settle();

    // R2 register index decode
    wr(16'h8000, 8'h12); expect_win(0, 8'h12, 1'b1, "R2 win0"); settle();
    wr(16'hD800, 8'h07); expect_win(11, 8'h07, 1'b0, "R2 win11"); settle();

    // R5 forced while reset force bits are set
    wr(16'h8800, 8'hE5); expect_win(1, 8'hE5, 1'b1, "R5 forced lo"); settle();
    // R4 threshold and page mask
    wr(16'hE800, 8'h05);
    expect_win(1, 8'hE5, 1'b0, "R4 ram page two-page");
    expect_val(25, 5, "R3 prg1"); settle();
    four_screen = 1'b1;
    wr(16'h8800, 8'hE6); expect_win(1, 8'hE6, 1'b0, "R4 ram page four-page"); settle();
    wr(16'h8000, 8'hDF); expect_win(0, 8'hDF, 1'b0, "R4 just below threshold"); settle();

    // R5 upper half
    wr(16'hA000, 8'hF0); expect_win(4, 8'hF0, 1'b0, "R5 hi clear"); settle();
    wr(16'hE800, 8'h85);
    expect_win(4, 8'hF0, 1'b1, "R5 hi forced");
    expect_win(1, 8'hE6, 1'b0, "R5 lo unaffected by hi"); settle();

    // R6 nametable never forced
    wr(16'hE800, 8'hC5); expect_win(1, 8'hE6, 1'b1, "R5 lo forced again"); settle();
    wr(16'hC800, 8'hE3); expect_win(9, 8'hE3, 1'b0, "R6 nametable ram"); settle();
    wr(16'hC000, 8'h33); expect_win(8, 8'h33, 1'b0, "R6 nametable rom"); settle();

    // R3 program banks
    wr(16'hE000, 8'hFF); expect_val(24, 63, "R3 prg0"); settle();
    wr(16'hF000, 8'h41);
    expect_val(26, 1, "R3 prg2 low bits");
    expect_val(27, 63, "R3 fixed window"); settle();

    // R7 write protect
    wr(16'hF800, 8'h45); expect_val(28, m_slots(8'h45), "R7 mixed"); settle();
    wr(16'hF800, 8'h50); expect_val(28, m_slots(8'h50), "R7 wrong key"); settle();
    wr(16'hF800, 8'hC0); expect_val(28, m_slots(8'hC0), "R7 key high bit"); settle();
    wr(16'hF800, 8'h40); expect_val(28, m_slots(8'h40), "R7 all open"); settle();

    // R8 low writes ignored
    wr(16'h6000, 8'h00);
    wr(16'h7800, 8'h11);
    wr(16'h4800, 8'h22);
    wr(16'h5800, 8'hE0);
    expect_val(28, 15, "R8 wram unchanged");
    expect_win(0, 8'hDF, 1'b0, "R8 win0 unchanged");
    expect_win(11, 8'h07, 1'b0, "R8 win11 unchanged");
    expect_val(24, 63, "R8 prg0 unchanged"); settle();

    // R9 latency: old value before the edge, new value after
    @(negedge clk);
    wr_en = 1'b1; wr_page = 5'h12; wr_data = 8'h44;
    #1 check(2, 2, "R9 before edge");
    @(negedge clk);
    wr_en = 1'b0;
    check(2, 8'h44, "R9 after edge");

    repeat (3) @(posedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule